// File: doc/BRIEF.md
# Scaler Initial Phase Calculator

This unit works out the starting filter phase for one axis of an image scaler. It takes the axis scale factor, the ratio of source size to destination size in 16.16 fixed point, together with the chroma subsampling factor of the plane (one or two) and a flag that asks for co-sited chroma. The phase is counted from the outer edge of the first pixel, which lies half a pixel before its centre. Half a destination step is added, along with an extra offset when the chroma samples are co-sited.

The result is packed into a 16-bit phase word. A phase below zero is wrapped up by one whole pixel. A phase of zero or more sets a trip bit. A range flag is raised for diagnostics whenever the raw phase lies outside minus one half to plus one and a half. The unit registers its result one cycle after a request and holds it until the next request.

Top module: `scaler_phase_calc`

## Requirements
- R1: After reset `out_valid`, `phase_word` and `range_err` are all zero.
- R2: A request sampled with `in_valid` high at a rising edge drives `out_valid` high for exactly that following cycle. The result appears at the same edge.
- R3: The raw phase, in units of 1/65536 pixel, is -32768 plus `scale_in` divided by twice the subsampling factor, where the quotient is rounded down.
- R4: With `cosited` high and a subsampling factor of two, 16384 is added to the raw phase. With a factor of one, `cosited` has no effect on any output.
- R5: A negative raw phase is increased by 65536 before encoding, and the trip bit (bit 14 of `phase_word`) is then zero.
- R6: A raw phase of zero or more is encoded unchanged, and bit 14 of `phase_word` is one. In both cases bits 13:0 hold bits 15:2 of the (possibly wrapped) phase.
- R7: Bit 15 of `phase_word` is always zero.
- R8: `range_err` is one exactly when the raw phase is below -32768 or above 98304. A raw phase of exactly 98304 does not raise it.
- R9: While `in_valid` is low, `phase_word` and `range_err` keep their values.
- R10: `sub_sel` encodes the subsampling factor: 0 selects a factor of one, and 1 selects a factor of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; the inputs below are sampled when it is high |
| scale_in | input | 32 | Scale factor, source over destination, unsigned 16.16 |
| sub_sel | input | 1 | Subsampling factor select (0: one, 1: two) |
| cosited | input | 1 | Co-sited chroma request |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| phase_word | output | 16 | Encoded phase: bit 14 is the trip bit, bits 13:0 are the phase field |
| range_err | output | 1 | Raw phase lay outside the legal window |

## Verification
Several properties are checked on every cycle: the one-cycle valid timing, the zero top bit, and trip-bit polarity tied to the accumulator's sign. The checks also cover the nonzero field of a wrapped negative phase, the quiet range flag for small scale factors, and the hold of outputs between requests. The exact arithmetic needs the bench's scenarios, compared against its own model. That arithmetic covers the truncating division and the co-sited offset for each subsampling factor, the boundary at exactly one and a half pixels, and the fact that `cosited` is ignored at a factor of one.

// File: rtl/scaler_phase_pkg.sv
package scaler_phase_pkg;

  typedef enum logic {
    SUB_BY_ONE = 1'b0,
    SUB_BY_TWO = 1'b1
  } sub_factor_e;

endpackage

// File: rtl/phase_accum.sv
module phase_accum
  import scaler_phase_pkg::*;
#(
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 16,
  localparam int ACC_W  = SCALE_W + 2
) (
  input  logic [SCALE_W-1:0]      scale,
  input  sub_factor_e             sub_f,
  input  logic                    cosited,
  output logic signed [ACC_W-1:0] phase
);

  localparam logic signed [ACC_W-1:0] START_PH = -(ACC_W'(2 ** (FRAC_W - 1)));
  localparam logic signed [ACC_W-1:0] COS_OFF  = ACC_W'(2 ** (FRAC_W - 2));

  // raw phase: edge start, optional siting shift, half a destination step
  function automatic logic signed [ACC_W-1:0] raw_phase(
    input logic [SCALE_W-1:0] sc,
    input sub_factor_e        sf,
    input logic               cs
  );
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] step;
    acc = START_PH;
    if (cs && sf == SUB_BY_TWO) acc = acc + COS_OFF;
    if (sf == SUB_BY_TWO) step = ACC_W'(sc >> 2);
    else                  step = ACC_W'(sc >> 1);
    return acc + step;
  endfunction

  assign phase = raw_phase(scale, sub_f, cosited);

endmodule

// File: rtl/phase_encode.sv
module phase_encode #(
  parameter int ACC_W  = 34,
  parameter int FRAC_W = 16,
  localparam int FIELD_W = FRAC_W - 2
) (
  input  logic signed [ACC_W-1:0] phase,
  output logic [FRAC_W-1:0]       word,
  output logic                    is_neg,
  output logic                    out_of_range
);

  localparam logic signed [ACC_W-1:0] ONE_PX = ACC_W'(2 ** FRAC_W);
  localparam logic signed [ACC_W-1:0] LO_LIM = -(ACC_W'(2 ** (FRAC_W - 1)));
  localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'(3 * (2 ** (FRAC_W - 1)));

  function automatic logic [FRAC_W-1:0] pack_word(input logic signed [ACC_W-1:0] p);
    logic signed [ACC_W-1:0] used;
    logic                    trip;
    trip = ~p[ACC_W-1];
    used = trip ? p : p + ONE_PX;
    return {1'b0, trip, used[FRAC_W-1:2]};
  endfunction

  function automatic logic range_bad(input logic signed [ACC_W-1:0] p);
    return (p < LO_LIM) || (p > HI_LIM);
  endfunction

  assign is_neg       = phase[ACC_W-1];
  assign word         = pack_word(phase);
  assign out_of_range = range_bad(phase);

endmodule

// File: rtl/scaler_phase_calc.sv
module scaler_phase_calc
  import scaler_phase_pkg::*;
#(
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [SCALE_W-1:0] scale_in,
  input  logic               sub_sel,
  input  logic               cosited,
  output logic               out_valid,
  output logic [FRAC_W-1:0]  phase_word,
  output logic               range_err
);

  localparam int ACC_W = SCALE_W + 2;

  sub_factor_e             sub_f;
  logic signed [ACC_W-1:0] raw_phase;
  logic                    raw_neg;
  logic [FRAC_W-1:0]       enc_word;
  logic                    enc_err;

  assign sub_f = sub_factor_e'(sub_sel);

  phase_accum #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) u_accum (
    .scale   (scale_in),
    .sub_f   (sub_f),
    .cosited (cosited),
    .phase   (raw_phase)
  );

  phase_encode #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_encode (
    .phase        (raw_phase),
    .word         (enc_word),
    .is_neg       (raw_neg),
    .out_of_range (enc_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      phase_word <= '0;
      range_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        phase_word <= enc_word;
        range_err  <= enc_err;
      end
    end
  end

endmodule

// File: rtl/scaler_phase_calc_chk.sv
module scaler_phase_calc_chk #(
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 16,
  localparam int ACC_W  = SCALE_W + 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [SCALE_W-1:0]      scale_in,
  input logic                    out_valid,
  input logic [FRAC_W-1:0]       phase_word,
  input logic                    range_err,
  input logic                    raw_neg
);

  localparam int TRIP_BIT = FRAC_W - 2;
  localparam logic [SCALE_W-1:0] SAFE_SCALE = SCALE_W'(4 * (2 ** FRAC_W));

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_top_bit_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_word[FRAC_W-1]);
  assert_wrap_no_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && raw_neg) |=> (!phase_word[TRIP_BIT] && phase_word[TRIP_BIT-1]));
  assert_trip_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !raw_neg) |=> phase_word[TRIP_BIT]);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scale_in <= SAFE_SCALE) |=> !range_err);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(phase_word) && $stable(range_err)));

endmodule

bind scaler_phase_calc scaler_phase_calc_chk #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .scale_in   (scale_in),
  .out_valid  (out_valid),
  .phase_word (phase_word),
  .range_err  (range_err),
  .raw_neg    (raw_neg)
);

// File: tb/test_scaler_phase_calc.sv
module test_scaler_phase_calc;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] scale_in = '0;
  logic        sub_sel = 1'b0;
  logic        cosited = 1'b0;
  logic        out_valid;
  logic [15:0] phase_word;
  logic        range_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scaler_phase_calc i_scaler_phase_calc (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .scale_in   (scale_in),
    .sub_sel    (sub_sel),
    .cosited    (cosited),
    .out_valid  (out_valid),
    .phase_word (phase_word),
    .range_err  (range_err)
  );

  // independent model, in plain integer arithmetic
  function automatic longint model_phase(input longint sc, input bit two, input bit cs);
    longint p;
    p = -32768;
    if (two && cs) p = p + 16384;
    p = p + (two ? sc / 4 : sc / 2);
    return p;
  endfunction

  function automatic logic [15:0] model_word(input longint p);
    longint q;
    longint w;
    q = (p < 0) ? p + 65536 : p;
    w = (q / 4) % 16384;
    if (p >= 0) w = w + 16384;
    return 16'(w);
  endfunction

  function automatic bit model_err(input longint p);
    return (p < -32768) || (p > 98304);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive one request, sample one edge later
  task automatic request(input logic [31:0] sc, input bit two, input bit cs);
    @(negedge clk);
    in_valid = 1'b1; scale_in = sc; sub_sel = two; cosited = cs;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_model(input string req, input logic [31:0] sc, input bit two, input bit cs);
    longint p;
    request(sc, two, cs);
    p = model_phase(longint'(sc), two, cs);
    check({req, " word"}, phase_word, model_word(p));
    check({req, " err"}, range_err, model_err(p));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w_a;
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", out_valid, 0);
    check("R1 phase_word", phase_word, 0);
    check("R1 range_err", range_err, 0);
    rst_n = 1'b1;

    // R2 valid pulse timing
    @(negedge clk);
    in_valid = 1'b1; scale_in = 32'h10000; sub_sel = 1'b0; cosited = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 pulse high", out_valid, 1);
    check("R3 identity", phase_word, 16'h4000);
    @(negedge clk);
    check("R2 pulse low", out_valid, 0);

    // R3 / R6 directed corners
    request(32'h40000, 1'b0, 1'b0);
    check("R6 downscale 4:1", phase_word, 16'h6000);
    check("R8 exact upper limit", range_err, 0);
    request(32'h04000, 1'b0, 1'b0);
    check("R5 upscale 1:4", phase_word, 16'h2800);
    request(32'h0, 1'b0, 1'b0);
    check("R5 zero scale", phase_word, 16'h2000);
    check("R7 top bit", phase_word[15], 0);
    request(32'h40002, 1'b0, 1'b0);
    check("R8 above limit flag", range_err, 1);
    check("R8 above limit word", phase_word, 16'h6000);

    // R10 / R4 sub factor and siting
    request(32'h10000, 1'b1, 1'b0);
    check("R10 sub two", phase_word, 16'h3000);
    request(32'h10000, 1'b1, 1'b1);
    check("R4 cosited sub two", phase_word, 16'h4000);
    request(32'h04000, 1'b0, 1'b0);
    w_a = phase_word;
    request(32'h04000, 1'b0, 1'b1);
    check("R4 cosited ignored sub one", phase_word, w_a);

    // R9 hold while idle with changing inputs
    request(32'h70004, 1'b1, 1'b1);
    check("R8 sub two flag", range_err, 1);
    w_a = phase_word;
    @(negedge clk);
    scale_in = 32'h00100; sub_sel = 1'b0; cosited = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 hold word", phase_word, w_a);
    check("R9 hold err", range_err, 1);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] sc;
      sc = (i % 3 == 0) ? $urandom() : 32'($urandom_range(0, 32'h80000));
      run_model("R3 R6 random", sc, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule